// File: doc/BRIEF.md
# Counter-Compare Pretrigger Channel

This block is one trigger channel of a delay-block timer. A shared free-running counter, kept outside the block, is compared every clock against two programmed delay values, one per pretrigger slot. When the counter equals a slot's delay and that slot is enabled, the channel sends a one-clock pretrigger pulse to a single downstream converter.

Each delay is double buffered. Software writes into a pending copy. A load strobe, issued at counter wrap, moves every pending copy into its active copy in the same clock. Reads of a delay register return the active copy.

The channel also tracks whether the converter is busy. A pretrigger is accepted only when no conversion is in progress. A match that cannot be accepted produces no pulse and sets a sticky per-slot sequence-error flag. Software clears that flag by writing 1 to it.

Top module: `pt_channel`

## Requirements
- R1: After synchronous active-low reset, both delay registers read 0, the error register reads 0, `conv_busy` is 0 and `pretrig` is 0.
- R2: The register map is: address 0 is the error register, address 1 is delay 0, address 2 is delay 1, and address 3 reads 0. A delay register holds 16 bits. Its bits 31:16 read 0, and write data in those bits is discarded.
- R3: A delay write reaches only the pending copy. Until the next `load_stb`, reads keep returning the previous active value, and the compare keeps using that previous value.
- R4: A `load_stb` clock copies the pending values of both slots into their active copies in that same clock.
- R5: When `cnt_val` equals slot m's active delay, `slot_en[m]` is 1 and the converter is idle, `pretrig[m]` is 1 for exactly the one clock after that compare cycle.
- R6: `conv_busy` rises in the clock a pretrigger is accepted. `conv_done` clears it. A match that arrives in the same clock as `conv_done` is accepted, and `conv_busy` stays 1.
- R7: A match on slot m while busy, with no `conv_done`, gives no pulse and sets error bit m. The bit stays 1 until software clears it.
- R8: A slot whose `slot_en` bit is 0 neither pulses nor sets its error bit, even when the counter matches its delay.
- R9: Error bit m sits at bit position m of the error register. Bits 31:2 read 0. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: If a rejection and a software clear hit the same error bit in the same clock, the bit ends up set.
- R11: If both slots match in the same clock while the converter is idle, slot 0 is accepted and slot 1 is rejected with its error bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Shared delay counter value |
| load_stb | input | 1 | Moves pending delays into the active copies |
| slot_en | input | 2 | Per-slot pretrigger enable |
| conv_done | input | 1 | Converter finished its conversion |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| pretrig | output | 2 | Per-slot pretrigger pulse |
| conv_busy | output | 1 | A conversion is in progress |

## Verification
Every result in this block is due one clock edge after the cycle in which its cause is presented: pretrigger pulses, the busy flag, error set and error clear, pending-copy writes and the load into the active copy. Reads are combinational from the address and show the registered state with no further delay. The bench drives each stimulus on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. A pulse is then checked again one clock later to confirm that it has ended.

// File: rtl/pt_pkg.sv
// Package: shared constants for the pretrigger channel.
// Assumes a 32-bit register port and an 8-bit error field of which
// only the low slot-count bits are implemented.
package pt_pkg;
    localparam int REG_W       = 32;
    localparam int ERR_FIELD_W = 8;
    localparam int ADDR_ERR    = 0;   // delay slot k lives at address k+1
endpackage

// File: rtl/pt_delay_bank.sv
// Module: pending/active delay storage, one pair per slot.
// Writes land in the pending copy; load_stb copies all pending values
// into the active copies in the same clock. Assumes one write at a time.
module pt_delay_bank #(
    parameter int NSLOT = 2,
    parameter int DLY_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSLOT-1:0]             wr_en,
    input  logic [DLY_W-1:0]             wdata,
    input  logic                         load_stb,
    output logic [NSLOT-1:0][DLY_W-1:0]  active
);
    logic [NSLOT-1:0][DLY_W-1:0] pending;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        // Capture software writes into the pending copy.
        always_ff @(posedge clk) begin
            if (!rst_n)        pending[k] <= '0;
            else if (wr_en[k]) pending[k] <= wdata;
        end

        // Promote pending to active on the load strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)        active[k] <= '0;
            else if (load_stb) active[k] <= pending[k];
        end

        a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb |=> active[k] == $past(pending[k]));
        a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
            !load_stb |=> $stable(active[k]));
    end
endmodule

// File: rtl/pt_compare_arb.sv
// Module: counter compare, acceptance and converter-busy tracking.
// A match is accepted when idle or when conv_done arrives in the same
// clock; the lowest slot wins a tie. Other matches are reported as
// rejects. Assumes cnt_val is synchronous to clk.
module pt_compare_arb #(
    parameter int NSLOT = 2,
    parameter int DLY_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DLY_W-1:0]             cnt_val,
    input  logic [NSLOT-1:0][DLY_W-1:0]  active,
    input  logic [NSLOT-1:0]             slot_en,
    input  logic                         conv_done,
    output logic [NSLOT-1:0]             reject,
    output logic [NSLOT-1:0]             pretrig,
    output logic                         busy
);
    logic [NSLOT-1:0] accept;

    // Compare each slot and grant at most one when the converter is free.
    always_comb begin
        logic free;
        logic taken;
        free   = !busy || conv_done;
        taken  = 1'b0;
        accept = '0;
        reject = '0;
        for (int m = 0; m < NSLOT; m++) begin
            if (slot_en[m] && (cnt_val == active[m])) begin
                if (free && !taken) begin
                    accept[m] = 1'b1;
                    taken     = 1'b1;
                end else begin
                    reject[m] = 1'b1;
                end
            end
        end
    end

    // Register the one-clock pretrigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pretrig <= '0;
        else        pretrig <= accept;
    end

    // Busy is set on acceptance and cleared by conversion complete.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (|accept)   busy <= 1'b1;
        else if (conv_done) busy <= 1'b0;
    end

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pretrig));
    a_r6_busy_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|pretrig) |-> busy);
    for (genvar m = 0; m < NSLOT; m++) begin : g_chk
        a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_en[m] |=> !pretrig[m]);
    end
endmodule

// File: rtl/pt_err_flags.sv
// Module: sticky per-slot sequence-error flags with write-1-to-clear.
// A hardware set outranks a software clear in the same clock.
module pt_err_flags #(
    parameter int NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] set_in,
    input  logic [NSLOT-1:0] clr_in,
    output logic [NSLOT-1:0] err_q
);
    // Update each flag: set wins, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= set_in | (err_q & ~clr_in);
    end

    for (genvar m = 0; m < NSLOT; m++) begin : g_chk
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_in[m] |=> err_q[m]);
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[m] && !clr_in[m]) |=> err_q[m]);
    end
endmodule

// File: rtl/pt_channel.sv
// Module: top of the pretrigger channel. Decodes the register port,
// connects the delay bank, the compare/arbiter and the error flags, and
// builds read data. Assumes NSLOT <= ERR_FIELD_W and DLY_W <= REG_W.
module pt_channel #(
    parameter int NSLOT  = 2,
    parameter int DLY_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DLY_W-1:0]        cnt_val,
    input  logic                    load_stb,
    input  logic [NSLOT-1:0]        slot_en,
    input  logic                    conv_done,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic [pt_pkg::REG_W-1:0] reg_wdata,
    output logic [pt_pkg::REG_W-1:0] reg_rdata,
    output logic [NSLOT-1:0]        pretrig,
    output logic                    conv_busy
);
    import pt_pkg::*;

    logic [NSLOT-1:0]            dly_wr;
    logic [NSLOT-1:0]            err_clr;
    logic [NSLOT-1:0]            reject;
    logic [NSLOT-1:0]            err_q;
    logic [NSLOT-1:0][DLY_W-1:0] active;

    // Decode writes into per-slot delay strobes and error clears.
    always_comb begin
        for (int k = 0; k < NSLOT; k++)
            dly_wr[k] = reg_wr && (reg_addr == ADDR_W'(k + 1));
        err_clr = (reg_wr && reg_addr == ADDR_W'(ADDR_ERR)) ? reg_wdata[NSLOT-1:0] : '0;
    end

    // Build read data; unimplemented bits and addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_ERR))
            reg_rdata[NSLOT-1:0] = err_q;
        for (int k = 0; k < NSLOT; k++)
            if (reg_addr == ADDR_W'(k + 1))
                reg_rdata[DLY_W-1:0] = active[k];
    end

    pt_delay_bank #(.NSLOT(NSLOT), .DLY_W(DLY_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(dly_wr), .wdata(reg_wdata[DLY_W-1:0]),
        .load_stb(load_stb), .active(active)
    );

    pt_compare_arb #(.NSLOT(NSLOT), .DLY_W(DLY_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .active(active),
        .slot_en(slot_en), .conv_done(conv_done), .reject(reject),
        .pretrig(pretrig), .busy(conv_busy)
    );

    pt_err_flags #(.NSLOT(NSLOT)) u_err (
        .clk(clk), .rst_n(rst_n), .set_in(reject), .clr_in(err_clr), .err_q(err_q)
    );

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:ERR_FIELD_W*2] == '0);
endmodule

// File: tb/sim_pt_channel.sv
module sim_pt_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = 16'hFFFF;
    logic        load_stb = 1'b0;
    logic [1:0]  slot_en = 2'b11;
    logic        conv_done = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pretrig;
    logic        conv_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_channel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .load_stb(load_stb),
        .slot_en(slot_en), .conv_done(conv_done), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pretrig(pretrig), .conv_busy(conv_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge for sampling/driving.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic load();
        load_stb = 1'b1; step(); load_stb = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 err", 2'd0, 0);
        rd_chk("R1 dly0", 2'd1, 0);
        rd_chk("R1 dly1", 2'd2, 0);
        chk("R1 busy", {31'd0, conv_busy}, 0);
        chk("R1 pretrig", {30'd0, pretrig}, 0);
    endtask

    task automatic t_delay_regs();
        wr(2'd1, 32'hABCD_1234);
        wr(2'd2, 32'h9999_0055);
        rd_chk("R3 dly0 before load", 2'd1, 0);
        load();
        rd_chk("R4 R2 dly0 after load", 2'd1, 32'h0000_1234);
        rd_chk("R4 R2 dly1 after load", 2'd2, 32'h0000_0055);
        rd_chk("R2 addr3 zero", 2'd3, 0);
    endtask

    task automatic t_fire();
        cnt_val = 16'h1234; step(); cnt_val = 16'hFFFF;
        chk("R5 pulse slot0", {30'd0, pretrig}, 32'h1);
        chk("R6 busy set", {31'd0, conv_busy}, 1);
        step();
        chk("R5 pulse one clock", {30'd0, pretrig}, 0);
    endtask

    task automatic t_busy_reject();
        cnt_val = 16'h0055; step(); cnt_val = 16'hFFFF;
        chk("R7 no pulse busy", {30'd0, pretrig}, 0);
        rd_chk("R7 err1 set", 2'd0, 32'h2);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        chk("R6 busy cleared", {31'd0, conv_busy}, 0);
        rd_chk("R7 err1 sticky", 2'd0, 32'h2);
    endtask

    task automatic t_done_same();
        cnt_val = 16'h1234; step();
        cnt_val = 16'h0055; conv_done = 1'b1; step();
        cnt_val = 16'hFFFF; conv_done = 1'b0;
        chk("R6 accepted with done", {30'd0, pretrig}, 32'h2);
        chk("R6 busy stays", {31'd0, conv_busy}, 1);
        conv_done = 1'b1; step(); conv_done = 1'b0;
    endtask

    task automatic t_disabled();
        slot_en = 2'b01;
        cnt_val = 16'h0055; step(); cnt_val = 16'hFFFF;
        chk("R8 no pulse", {30'd0, pretrig}, 0);
        chk("R8 no busy", {31'd0, conv_busy}, 0);
        rd_chk("R8 err unchanged", 2'd0, 32'h2);
        slot_en = 2'b11;
    endtask

    task automatic t_w1c();
        wr(2'd0, 32'h0000_0001);
        rd_chk("R9 write0 keeps bit", 2'd0, 32'h2);
        wr(2'd0, 32'hFFFF_FFFE);
        rd_chk("R9 w1c clears", 2'd0, 0);
    endtask

    task automatic t_set_wins();
        cnt_val = 16'h1234; step();
        cnt_val = 16'h0055;
        reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 32'h2;
        step();
        reg_wr = 1'b0; reg_wdata = '0; cnt_val = 16'hFFFF;
        rd_chk("R10 set wins", 2'd0, 32'h2);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        wr(2'd0, 32'h3);
    endtask

    task automatic t_pending();
        wr(2'd1, 32'h0000_0777);
        cnt_val = 16'h0777; step(); cnt_val = 16'hFFFF;
        chk("R3 pending not compared", {30'd0, pretrig}, 0);
        rd_chk("R3 active kept", 2'd1, 32'h1234);
        wr(2'd1, 32'h0000_1234);
    endtask

    task automatic t_tie();
        wr(2'd2, 32'h0000_1234);
        load();
        cnt_val = 16'h1234; step(); cnt_val = 16'hFFFF;
        chk("R11 slot0 wins", {30'd0, pretrig}, 32'h1);
        rd_chk("R11 slot1 error", 2'd0, 32'h2);
        conv_done = 1'b1; step(); conv_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_delay_regs();
        t_fire();
        t_busy_reject();
        t_done_same();
        t_disabled();
        t_w1c();
        t_set_wins();
        t_pending();
        t_tie();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule